// File: doc/BRIEF.md
# Control Line Interrupt and Handshake Unit

This block serves one side of a parallel peripheral port. It watches two peripheral control lines: line one, which is input only, and line two, which can be an input or an output. It detects a programmed edge on each line and latches it into a status flag. It raises the side's interrupt request from those flags and their enable bits. When line two is an output, the block also drives it, either as a static level or as an automatic handshake strobe that the block produces around host accesses to the port's data register.

The host bus interface supplies four things: a six-bit configuration field, one-cycle pulses that mark the rising and falling edges of the bus enable strobe, the chip-select state, and one-cycle pulses that mark host reads and writes of the data register. All logic runs on one system clock. The two peripheral lines pass through synchronizers before any edge logic sees them. The parameter `SIDE_B` picks the handshake variant. With `SIDE_B=0`, the strobe follows data reads and is timed by enable falling edges. With `SIDE_B=1`, the strobe follows data writes and is timed by enable rising edges.

Top module: `cl_ctrl_line_unit`

## Requirements
- R1: Configuration bit 1 sets the active edge of line one: 0 means high-to-low and 1 means low-to-high. An active edge sets flag7, which is `flags_o[1]`.
- R2: An edge counts only if an enable falling-edge pulse saw the line at its inactive level before the edge. A transition with no such pulse before it leaves the flags unchanged.
- R3: `irq_o` is high exactly when (flag7 and bit 0) or (flag6 and bit 3 and not bit 5) holds. If a flag is already set when its enable bit is turned on, the request rises at once.
- R4: When bit 5 is 0, line two is an input. Bit 4 selects its active edge, coded as for bit 1. An active edge sets flag6, which is `flags_o[0]`, and bit 3 enables the request from flag6.
- R5: When bit 5 is 1, flag6 is held at 0 and transitions on line two have no effect on it.
- R6: A data-register read pulse clears both flags. After that, neither flag can be set again until an enable falling edge occurs with chip select low.
- R7: `c2_oe_o` equals bit 5. When bits 5:4 are 11, `c2_o` equals bit 3.
- R8: Side A, bits 5:3 = 100: `c2_o` goes low on the first enable falling edge after the one that carried a data read. It returns high on the next active line-one edge.
- R9: Side A, bits 5:3 = 101: the strobe goes low as in R8. It returns high on the next enable falling edge that occurs while chip select is low.
- R10: Side B, bits 5:3 = 100: `c2_o` goes low on the first enable rising edge after a data write. It returns high on the next active line-one edge.
- R11: Side B, bits 5:3 = 101: the strobe goes low as in R10. It returns high on the first enable rising edge after an enable pulse during which chip select was low.
- R12: After reset, both flags and `irq_o` are 0, `c2_oe_o` is 0 and `c2_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 6 | Configuration bits 5:0 |
| e_rise_i | input | 1 | Pulse marking an enable rising edge |
| e_fall_i | input | 1 | Pulse marking an enable falling edge |
| sel_i | input | 1 | Chip-select state during the current enable pulse |
| data_rd_i | input | 1 | Pulse marking a host read of the data register |
| data_wr_i | input | 1 | Pulse marking a host write of the data register |
| c1_i | input | 1 | Control line one (input only) |
| c2_i | input | 1 | Control line two, input value |
| flags_o | output | 2 | {flag7, flag6} status bits |
| irq_o | output | 1 | Interrupt request; high pulls the open-drain pin low |
| c2_o | output | 1 | Control line two output value |
| c2_oe_o | output | 1 | Control line two output enable |

## Verification
The bench builds two instances, one with `SIDE_B=0` and one with `SIDE_B=1`, and drives both from the same stimulus. Because both see the same inputs, a single access sequence shows the read strobe and the write strobe on their different enable edges. A check taken halfway through an enable pulse can therefore separate a rising-edge trigger from a falling-edge trigger. The shared sequence also covers the flag lockout after a read, edges that are not armed, and strobe restore by line one or by a deselected pulse.

// File: rtl/cl_pkg.sv
`timescale 1ns/1ps
package cl_pkg;
  localparam int CTRL_W = 6;

  // Field positions inside the configuration word
  localparam int B_IRQ1_EN = 0;
  localparam int B_C1_POL  = 1;
  localparam int B_C2_SEL  = 3;
  localparam int B_C2_POL  = 4;
  localparam int B_C2_OUT  = 5;

  // Line two operating mode, decoded from bits 5:4
  typedef enum logic [1:0] {
    C2M_IN_A   = 2'b00,
    C2M_IN_B   = 2'b01,
    C2M_STROBE = 2'b10,
    C2M_STATIC = 2'b11
  } c2_mode_e;
endpackage

// File: rtl/cl_sync.sv
`timescale 1ns/1ps
module cl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cl_edge_flag.sv
`timescale 1ns/1ps
// Armed edge detector with a latched flag and a post-clear lockout.
module cl_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,    // synchronized line level
  input  logic act_hi_i,  // 1: low-to-high is active
  input  logic en_i,      // detection enabled
  input  logic e_fall_i,
  input  logic sel_i,
  input  logic clr_i,
  output logic flag_o,
  output logic edge_o     // active edge seen this cycle
);
  logic arm_q, arm_d;
  logic lock_q, lock_d;
  logic flag_q, flag_d;
  logic at_active;
  logic hit;

  always_comb begin
    at_active = (line_i == act_hi_i);
    hit       = arm_q & en_i & at_active;

    // arming: an enable pulse must see the inactive level first
    arm_d = arm_q;
    if (!en_i || hit)              arm_d = 1'b0;
    else if (e_fall_i && !at_active) arm_d = 1'b1;

    // lockout after a clearing read, released by a deselected pulse
    lock_d = lock_q;
    if (clr_i)                    lock_d = 1'b1;
    else if (e_fall_i && !sel_i)  lock_d = 1'b0;

    flag_d = flag_q;
    if (clr_i || !en_i)           flag_d = 1'b0;
    else if (hit && !lock_q)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      lock_q <= lock_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign edge_o = hit;
endmodule

// File: rtl/cl_c2_strobe.sv
`timescale 1ns/1ps
// Automatic handshake strobe for control line two.
module cl_c2_strobe #(
  parameter bit SIDE_B = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,    // config bits 5:3
  input  logic       e_rise_i,
  input  logic       e_fall_i,
  input  logic       sel_i,
  input  logic       access_i,  // data read (A) or write (B)
  input  logic       c1_edge_i,
  output logic       level_o
);
  logic lvl_q, lvl_d;
  logic pend_q, pend_d;
  logic dsl_q, dsl_d;
  logic active;
  logic trig;
  logic e_restore;

  always_comb begin
    active = (mode_i[2:1] == 2'b10);
    trig   = SIDE_B ? e_rise_i : e_fall_i;
    e_restore = SIDE_B ? (e_rise_i & dsl_q) : (e_fall_i & ~sel_i);

    lvl_d  = lvl_q;
    pend_d = pend_q;
    dsl_d  = dsl_q;

    if (!active) begin
      lvl_d  = 1'b1;
      pend_d = 1'b0;
      dsl_d  = 1'b0;
    end else if (access_i) begin
      pend_d = 1'b1;
    end else if (pend_q && trig) begin
      lvl_d  = 1'b0;
      pend_d = 1'b0;
      dsl_d  = 1'b0;
    end else if (!lvl_q) begin
      if (!mode_i[0]) begin
        if (c1_edge_i) lvl_d = 1'b1;
      end else begin
        if (e_restore) begin
          lvl_d = 1'b1;
          dsl_d = 1'b0;
        end else if (e_fall_i && !sel_i) begin
          dsl_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      pend_q <= 1'b0;
      dsl_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
      dsl_q  <= dsl_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/cl_ctrl_line_unit.sv
`timescale 1ns/1ps
module cl_ctrl_line_unit #(
  parameter bit SIDE_B      = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [cl_pkg::CTRL_W-1:0] ctrl_i,
  input  logic                      e_rise_i,
  input  logic                      e_fall_i,
  input  logic                      sel_i,
  input  logic                      data_rd_i,
  input  logic                      data_wr_i,
  input  logic                      c1_i,
  input  logic                      c2_i,
  output logic [1:0]                flags_o,
  output logic                      irq_o,
  output logic                      c2_o,
  output logic                      c2_oe_o
);
  import cl_pkg::*;

  localparam int NLINES = 2;

  // reset: asserted asynchronously, released through a flop chain
  logic [RST_STAGES-1:0] rst_chain_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_chain_q[RST_STAGES-1];

  // per-line control
  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_pol;
  logic [NLINES-1:0] line_en;
  logic [NLINES-1:0] line_flag;
  logic [NLINES-1:0] line_edge;
  c2_mode_e          c2_mode;

  always_comb begin
    c2_mode     = c2_mode_e'(ctrl_i[B_C2_OUT:B_C2_POL]);
    line_raw    = {c2_i, c1_i};
    line_pol    = {ctrl_i[B_C2_POL], ctrl_i[B_C1_POL]};
    line_en     = {~ctrl_i[B_C2_OUT], 1'b1};
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    cl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_core_n),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );

    cl_edge_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .line_i   (line_s[g]),
      .act_hi_i (line_pol[g]),
      .en_i     (line_en[g]),
      .e_fall_i (e_fall_i),
      .sel_i    (sel_i),
      .clr_i    (data_rd_i),
      .flag_o   (line_flag[g]),
      .edge_o   (line_edge[g])
    );
  end

  // handshake strobe on line two
  logic strobe_lvl;
  logic port_access;

  assign port_access = SIDE_B ? data_wr_i : data_rd_i;

  cl_c2_strobe #(.SIDE_B(SIDE_B)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mode_i    (ctrl_i[B_C2_OUT:B_C2_SEL]),
    .e_rise_i  (e_rise_i),
    .e_fall_i  (e_fall_i),
    .sel_i     (sel_i),
    .access_i  (port_access),
    .c1_edge_i (line_edge[0]),
    .level_o   (strobe_lvl)
  );

  // outputs
  always_comb begin
    flags_o = {line_flag[0], line_flag[1]};
    irq_o   = (line_flag[0] & ctrl_i[B_IRQ1_EN])
            | (line_flag[1] & ctrl_i[B_C2_SEL] & ~ctrl_i[B_C2_OUT]);
    c2_oe_o = ctrl_i[B_C2_OUT];
    unique case (c2_mode)
      C2M_STATIC: c2_o = ctrl_i[B_C2_SEL];
      C2M_STROBE: c2_o = strobe_lvl;
      default:    c2_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cl_ctrl_line_chk.sv
`timescale 1ns/1ps
module cl_ctrl_line_chk #(
  parameter bit SIDE_B = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] ctrl_i,
  input logic       e_rise_i,
  input logic       e_fall_i,
  input logic       sel_i,
  input logic       data_rd_i,
  input logic [1:0] flags_o,
  input logic       irq_o,
  input logic       c2_o,
  input logic       c2_oe_o
);
  // R3: no request without a flag
  a_r3_no_req_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o == 2'b00) |-> !irq_o);

  // R3: an enabled flag drives the request
  a_r3_enabled_flag_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[1] && ctrl_i[0]) |-> irq_o);

  // R6: a data read empties both flags
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_i |=> (flags_o == 2'b00));

  // R5: output mode keeps flag6 low
  a_r5_flag6_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5] && $past(ctrl_i[5])) |-> !flags_o[0]);

  // R7: static output follows bit 3
  a_r7_static_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5:4] == 2'b11) |-> (c2_oe_o && (c2_o == ctrl_i[3])));

  if (SIDE_B) begin : g_b
    // R10: strobe falls only after an enable rising edge
    a_r10_fall_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(c2_o) && ctrl_i[5:4] == 2'b10 && $past(ctrl_i[5:4]) == 2'b10)
      |-> $past(e_rise_i));
    // R11: E-restore happens on an enable rising edge
    a_r11_rise_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(c2_o) && ctrl_i[5:3] == 3'b101 && $past(ctrl_i[5:3]) == 3'b101)
      |-> $past(e_rise_i));
  end else begin : g_a
    // R8: strobe falls only after an enable falling edge
    a_r8_fall_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(c2_o) && ctrl_i[5:4] == 2'b10 && $past(ctrl_i[5:4]) == 2'b10)
      |-> $past(e_fall_i));
    // R9: E-restore needs a deselected falling edge
    a_r9_rise_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(c2_o) && ctrl_i[5:3] == 3'b101 && $past(ctrl_i[5:3]) == 3'b101)
      |-> $past(e_fall_i && !sel_i));
  end
endmodule

bind cl_ctrl_line_unit cl_ctrl_line_chk #(.SIDE_B(SIDE_B)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_i    (ctrl_i),
  .e_rise_i  (e_rise_i),
  .e_fall_i  (e_fall_i),
  .sel_i     (sel_i),
  .data_rd_i (data_rd_i),
  .flags_o   (flags_o),
  .irq_o     (irq_o),
  .c2_o      (c2_o),
  .c2_oe_o   (c2_oe_o)
);

// File: tb/sim_cl_ctrl_line_unit.sv
`timescale 1ns/1ps
module sim_cl_ctrl_line_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic       e_rise = 1'b0, e_fall = 1'b0, sel = 1'b0;
  logic       drd = 1'b0, dwr = 1'b0, c1 = 1'b0, c2 = 1'b0;

  logic [1:0] fl_a, fl_b;
  logic irq_a, irq_b, c2o_a, c2o_b, oe_a, oe_b;

  always #2.5 clk = ~clk;

  cl_ctrl_line_unit #(.SIDE_B(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .e_rise_i(e_rise), .e_fall_i(e_fall),
    .sel_i(sel), .data_rd_i(drd), .data_wr_i(dwr), .c1_i(c1), .c2_i(c2),
    .flags_o(fl_a), .irq_o(irq_a), .c2_o(c2o_a), .c2_oe_o(oe_a));

  cl_ctrl_line_unit #(.SIDE_B(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .e_rise_i(e_rise), .e_fall_i(e_fall),
    .sel_i(sel), .data_rd_i(drd), .data_wr_i(dwr), .c1_i(c1), .c2_i(c2),
    .flags_o(fl_b), .irq_o(irq_b), .c2_o(c2o_b), .c2_oe_o(oe_b));

  // observed vector: {irq, c2_o, c2_oe, flag7, flag6}
  wire [4:0] obs_a = {irq_a, c2o_a, oe_a, fl_a};
  wire [4:0] obs_b = {irq_b, c2o_b, oe_b, fl_b};

  typedef struct {
    string    tag;
    int       dut;
    logic [4:0] exp;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: pops expectations and compares against the outputs
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = sb.pop_front();
      act = (it.dut == 0) ? obs_a : obs_b;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s side %s: actual %b expected %b", it.tag,
                 (it.dut == 0) ? "A" : "B", act, it.exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect2(string tag, logic [4:0] ea, logic [4:0] eb);
    item_t ia, ib;
    @(negedge clk);
    ia.tag = tag; ia.dut = 0; ia.exp = ea;
    ib.tag = tag; ib.dut = 1; ib.exp = eb;
    sb.push_back(ia);
    sb.push_back(ib);
  endtask

  task automatic e_up(bit s);
    @(negedge clk); sel = s; e_rise = 1'b1;
    @(negedge clk); e_rise = 1'b0;
    cyc(2);
  endtask

  task automatic e_down(bit s, bit rd, bit wr);
    @(negedge clk); sel = s; e_fall = 1'b1; drd = rd; dwr = wr;
    @(negedge clk); e_fall = 1'b0; drd = 1'b0; dwr = 1'b0;
    cyc(3);
  endtask

  task automatic pulse(bit s);
    e_up(s);
    e_down(s, 1'b0, 1'b0);
  endtask

  task automatic set_c1(bit v);
    @(negedge clk); c1 = v;
    cyc(4);
  endtask

  task automatic set_c2(bit v);
    @(negedge clk); c2 = v;
    cyc(4);
  endtask

  task automatic set_ctrl(logic [5:0] v);
    @(negedge clk); ctrl = v;
    cyc(2);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(5);
    expect2("R12 reset", 5'b01000, 5'b01000);

    // rising edge on line one, request disabled
    set_ctrl(6'b000010);
    pulse(1'b1);
    set_c1(1'b1);
    expect2("R1 rising edge sets flag7", 5'b01010, 5'b01010);

    set_ctrl(6'b000011);
    expect2("R3 pending request on enable", 5'b11010, 5'b11010);

    // clearing read
    e_up(1'b1);
    e_down(1'b1, 1'b1, 1'b0);
    expect2("R6 read clears flags", 5'b01000, 5'b01000);

    // lockout: selected pulse does not release it
    set_c1(1'b0);
    pulse(1'b1);
    set_c1(1'b1);
    expect2("R6 lockout holds", 5'b01000, 5'b01000);

    // deselected pulse releases lockout
    set_c1(1'b0);
    pulse(1'b0);
    set_c1(1'b1);
    expect2("R6 lockout released", 5'b11010, 5'b11010);

    // edge with no arming pulse
    e_up(1'b1);
    e_down(1'b1, 1'b1, 1'b0);
    pulse(1'b0);
    set_c1(1'b0);
    set_c1(1'b1);
    expect2("R2 unarmed edge ignored", 5'b01000, 5'b01000);

    // falling edge polarity
    set_ctrl(6'b000001);
    pulse(1'b0);
    set_c1(1'b0);
    expect2("R1 falling edge sets flag7", 5'b11010, 5'b11010);

    // line two as an input, rising edge, request enabled
    set_ctrl(6'b011001);
    e_up(1'b1);
    e_down(1'b1, 1'b1, 1'b0);
    pulse(1'b0);
    set_c2(1'b1);
    expect2("R4 line two edge sets flag6", 5'b11001, 5'b11001);
    set_ctrl(6'b010001);
    expect2("R4 bit3 gates flag6 request", 5'b01001, 5'b01001);

    // static output
    set_ctrl(6'b110001);
    expect2("R5 R7 output mode, static low", 5'b00100, 5'b00100);
    set_ctrl(6'b111001);
    expect2("R7 static high", 5'b01100, 5'b01100);
    set_c2(1'b0);
    pulse(1'b0);
    set_c2(1'b1);
    expect2("R5 line two ignored as output", 5'b01100, 5'b01100);

    // strobe, restored by line one (rising edge)
    set_ctrl(6'b100011);
    e_up(1'b1);
    e_down(1'b1, 1'b1, 1'b1);
    expect2("R8 R10 no strobe on access pulse", 5'b01100, 5'b01100);
    e_up(1'b1);
    expect2("R10 strobe low after rising edge", 5'b01100, 5'b00100);
    e_down(1'b1, 1'b0, 1'b0);
    expect2("R8 strobe low after falling edge", 5'b00100, 5'b00100);
    set_c1(1'b1);
    expect2("R8 R10 line one edge restores", 5'b01100, 5'b01100);

    // strobe, restored by enable
    set_ctrl(6'b101011);
    e_up(1'b1);
    e_down(1'b1, 1'b1, 1'b1);
    expect2("R9 R11 no strobe on access pulse", 5'b01100, 5'b01100);
    pulse(1'b1);
    expect2("R9 R11 strobe low", 5'b00100, 5'b00100);
    pulse(1'b1);
    expect2("R9 R11 selected pulse keeps low", 5'b00100, 5'b00100);
    e_up(1'b0);
    expect2("R11 no restore without earlier deselect", 5'b00100, 5'b00100);
    e_down(1'b0, 1'b0, 1'b0);
    expect2("R9 deselected fall restores A", 5'b01100, 5'b00100);
    e_up(1'b1);
    expect2("R11 next rise restores B", 5'b01100, 5'b01100);
    e_down(1'b1, 1'b0, 1'b0);

    cyc(3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule